// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits in the instruction fetch stage and produces the address to fetch in each cycle. It keeps a direct-mapped table of simple direct branches. Each entry holds the upper bits of a branch address as a tag, the branch target and a valid bit. While fetch runs sequentially, a valid entry whose tag matches the fetch address makes the next fetch go to the stored target. That fetch is flagged as predicted taken, so later pipeline stages can skip their own static guess for it.

The execute stage reports each resolved simple branch through an update port. The entry for that branch is rewritten with its address and target. The valid bit is set when the branch was taken and cleared when it was not. The table is read two instruction slots ahead of the current fetch, and the tag compare is given its own cycle. This keeps the lookup off the critical path. The cost is that a prediction is possible only from the third sequential fetch after any change of flow.

Fetch advances by one 4-byte instruction per cycle. An external redirect input sets the next fetch address directly.

Top module: `btc_fetch_predictor`

## Requirements
- R1: After reset, `fetch_addr` equals `RESET_ADDR` and `fetch_pred` is 0. Every entry is invalid, so no fetch is predicted until an update marks an entry valid.
- R2: When no redirect is taken and no prediction is made, `fetch_addr` increases by 4 each cycle and `fetch_pred` is 0.
- R3: In the cycle after `redir_valid` is high, `fetch_addr` equals `redir_addr` with its two low bits forced to 0, and `fetch_pred` is 0. An external redirect overrides a prediction that is due in the same cycle.
- R4: Suppose a fetch is at address B, it is the third or later sequential fetch, and the entry for B is valid with a matching tag. Then in the next cycle `fetch_addr` equals the stored target with its two low bits cleared, and `fetch_pred` is 1.
- R5: The entry index is address bits [IDX_BITS+1:2], and the tag is bits [AW-1:IDX_BITS+2]. A branch that maps to the same index with a different tag does not hit. It replaces the earlier entry when it is written.
- R6: An update with `upd_taken`=1 makes its entry valid. An update with `upd_taken`=0 for the same address clears the valid bit, and no prediction is made at that address afterwards.
- R7: After any change of flow, whether an external redirect or a prediction, the first and second fetches that follow are never predicted. The third and later fetches can be predicted.
- R8: The prediction at fetch address A uses the table contents as they stood in the cycle when `fetch_addr` was A-8. An update presented in that same cycle is not seen. An update presented in the cycle when `fetch_addr` was A-12 is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | External redirect request for the next fetch |
| redir_addr | input | AW | Address to fetch after a redirect |
| upd_valid | input | 1 | A simple branch was resolved this cycle |
| upd_addr | input | AW | Address of the resolved branch |
| upd_target | input | AW | Target of the resolved branch |
| upd_taken | input | 1 | Resolved branch was taken |
| fetch_addr | output | AW | Address fetched in this cycle |
| fetch_pred | output | 1 | This fetch came from a predicted-taken redirect |

## Verification
The two functions that can coincide are a table write from the update port and the read-ahead lookup of the same entry. The bench provokes this by presenting an update for branch address A exactly in the cycle when the fetch is at A-8. It then expects the stale contents to govern the fetch at A, so no prediction occurs. It repeats the update one cycle earlier, in the cycle when the fetch is at A-12, and then expects the new target. A second coincidence, an external redirect arriving in the same cycle as a due prediction, is judged by requiring that the redirect address wins. A sweep over every index of a 16-entry configuration redirects to 0, 1, 2 and 3 slots before a stored branch. It checks arithmetically that only the last two cases predict.

// File: rtl/btc_pkg.sv
package btc_pkg;
    // Source of the next fetch address
    typedef enum logic [1:0] {
        NPC_SEQ  = 2'd0,
        NPC_EXT  = 2'd1,
        NPC_PRED = 2'd2
    } npc_sel_e;
endpackage

// File: rtl/btc_valid.sv
module btc_valid #(
    parameter int IDX_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_BITS-1:0] rd_idx,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic                wr_val,
    output logic                rd_valid
);
    localparam int ENTRIES = 1 << IDX_BITS;

    logic [ENTRIES-1:0] bits_q, bits_d;
    logic               rd_q, rd_d;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            bits_d[wr_idx] = wr_val;
        end
        // read sees contents before this cycle's write
        rd_d = bits_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            bits_q <= bits_d;
            rd_q   <= rd_d;
        end
    end

    assign rd_valid = rd_q;
endmodule

// File: rtl/btc_store.sv
module btc_store #(
    parameter int IDX_BITS = 10,
    parameter int DW       = 50
) (
    input  logic                clk,
    input  logic [IDX_BITS-1:0] rd_idx,
    input  logic                wr_en,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [DW-1:0]       rd_data
);
    localparam int ENTRIES = 1 << IDX_BITS;

    logic [DW-1:0] mem_q [ENTRIES];
    logic [DW-1:0] rd_q;

    // read-before-write synchronous array, no reset on payload
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
        rd_q <= mem_q[rd_idx];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/btc_match.sv
module btc_match #(
    parameter int TAG_W = 20
) (
    input  logic             entry_valid,
    input  logic [TAG_W-1:0] entry_tag,
    input  logic [TAG_W-1:0] key_tag,
    output logic             hit
);
    always_comb begin
        hit = entry_valid && (entry_tag == key_tag);
    end
endmodule

// File: rtl/btc_fetch_predictor.sv
module btc_fetch_predictor
    import btc_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            IDX_BITS   = 10,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redir_valid,
    input  logic [AW-1:0] redir_addr,
    input  logic          upd_valid,
    input  logic [AW-1:0] upd_addr,
    input  logic [AW-1:0] upd_target,
    input  logic          upd_taken,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_pred
);
    localparam int WA_W  = AW - 2;          // word address width
    localparam int TAG_W = WA_W - IDX_BITS; // tag above the index
    localparam int DW    = TAG_W + WA_W;    // payload: tag + target

    typedef struct packed {
        logic [WA_W-1:0] pc;      // current fetch word address
        logic            pred;    // current fetch was predicted
        logic            s1_v;    // array read in flight is sequential
        logic            s2_v;    // compare result is sequential
        logic            s2_hit;  // compare result for current pc
        logic [WA_W-1:0] s2_tgt;  // target for current pc
    } state_t;

    state_t   st_q, st_d;
    npc_sel_e sel;
    logic     take_pred;
    logic     seq;

    logic [WA_W-1:0]     ahead_w;
    logic [WA_W-1:0]     next_w;
    logic [IDX_BITS-1:0] rd_idx;
    logic [IDX_BITS-1:0] wr_idx;
    logic [DW-1:0]       wr_data;
    logic [DW-1:0]       rd_data;
    logic [TAG_W-1:0]    rd_tag;
    logic [WA_W-1:0]     rd_tgt;
    logic                rd_valid;
    logic                s1_hit;
    logic                unused_lowbits;

    // read two slots ahead; the compare runs one slot ahead
    assign ahead_w = st_q.pc + WA_W'(2);
    assign next_w  = st_q.pc + WA_W'(1);
    assign rd_idx  = ahead_w[IDX_BITS-1:0];

    assign wr_idx  = upd_addr[IDX_BITS+1:2];
    assign wr_data = {upd_addr[AW-1:IDX_BITS+2], upd_target[AW-1:2]};
    assign {rd_tag, rd_tgt} = rd_data;

    assign unused_lowbits = ^{redir_addr[1:0], upd_addr[1:0], upd_target[1:0]};

    btc_valid #(.IDX_BITS(IDX_BITS)) u_valid (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_val   (upd_taken),
        .rd_valid (rd_valid)
    );

    btc_store #(.IDX_BITS(IDX_BITS), .DW(DW)) u_store (
        .clk     (clk),
        .rd_idx  (rd_idx),
        .wr_en   (upd_valid),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    btc_match #(.TAG_W(TAG_W)) u_match (
        .entry_valid (rd_valid),
        .entry_tag   (rd_tag),
        .key_tag     (next_w[WA_W-1:IDX_BITS]),
        .hit         (s1_hit)
    );

    always_comb begin
        st_d      = st_q;
        take_pred = st_q.s2_v && st_q.s2_hit && !redir_valid;
        seq       = !redir_valid && !take_pred;

        if (redir_valid) begin
            sel = NPC_EXT;
        end else if (take_pred) begin
            sel = NPC_PRED;
        end else begin
            sel = NPC_SEQ;
        end

        case (sel)
            NPC_EXT: begin
                st_d.pc   = redir_addr[AW-1:2];
                st_d.pred = 1'b0;
            end
            NPC_PRED: begin
                st_d.pc   = st_q.s2_tgt;
                st_d.pred = 1'b1;
            end
            default: begin
                st_d.pc   = next_w;
                st_d.pred = 1'b0;
            end
        endcase

        // any change of flow kills the lookups in flight
        st_d.s1_v   = seq;
        st_d.s2_v   = st_q.s1_v && seq;
        st_d.s2_hit = s1_hit;
        st_d.s2_tgt = rd_tgt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.pc     <= RESET_ADDR[AW-1:2];
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = {st_q.pc, 2'b00};
    assign fetch_pred = st_q.pred;
endmodule

// File: rtl/btc_fetch_predictor_chk.sv
module btc_fetch_predictor_chk #(
    parameter int            AW         = 32,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          redir_valid,
    input logic [AW-1:0] redir_addr,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_pred
);
    logic first_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        first_q <= rst;
        armed_q <= !rst;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        first_q |-> (fetch_addr == RESET_ADDR) && !fetch_pred); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |=> fetch_pred || (fetch_addr == $past(fetch_addr) + AW'(4))); // R2

    AST_EXT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !fetch_pred && (fetch_addr == ($past(redir_addr) & ~AW'(3)))); // R3

    AST_SECOND_FETCH_UNPREDICTED: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(redir_valid) && !redir_valid |=> !fetch_pred); // R7

    AST_AFTER_PRED_UNPREDICTED: assert property (@(posedge clk) disable iff (rst)
        fetch_pred && !redir_valid |=> !fetch_pred); // R7
endmodule

bind btc_fetch_predictor btc_fetch_predictor_chk #(
    .AW         (AW),
    .RESET_ADDR (RESET_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .fetch_addr  (fetch_addr),
    .fetch_pred  (fetch_pred)
);

// File: tb/sim_btc_fetch_predictor.sv
module sim_btc_fetch_predictor;
    localparam int AW   = 16;
    localparam int IDXB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_addr = '0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic          fetch_pred;

    int n_tests = 0;
    int n_fail  = 0;

    always #10ns clk = ~clk;

    btc_fetch_predictor #(.AW(AW), .IDX_BITS(IDXB), .RESET_ADDR(16'h0000)) u0 (
        .clk(clk), .rst(rst),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_target(upd_target), .upd_taken(upd_taken),
        .fetch_addr(fetch_addr), .fetch_pred(fetch_pred)
    );

    task automatic chk(input string req, input logic [AW-1:0] ea, input logic ep);
        n_tests++;
        if (fetch_addr !== ea || fetch_pred !== ep) begin
            n_fail++;
            $display("FAIL %s: addr=%h pred=%b expected addr=%h pred=%b",
                     req, fetch_addr, fetch_pred, ea, ep);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic redir(input logic [AW-1:0] a);
        redir_valid = 1'b1;
        redir_addr  = a;
        step();
        redir_valid = 1'b0;
    endtask

    task automatic upd(input logic [AW-1:0] a, input logic [AW-1:0] t, input logic tk);
        upd_valid  = 1'b1;
        upd_addr   = a;
        upd_target = t;
        upd_taken  = tk;
        step();
        upd_valid  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        chk("R1 reset state", 16'h0000, 1'b0);
        // all entries invalid: plain sequential stepping over every index
        for (int s = 1; s <= 20; s++) begin
            step();
            chk("R1/R2 sequential after reset", AW'(4 * s), 1'b0);
        end

        // R4: basic hit on third sequential fetch
        upd(16'h0040, 16'h0200, 1'b1);
        redir(16'h0038); chk("R3 redirect", 16'h0038, 1'b0);
        step(); chk("R2 seq", 16'h003C, 1'b0);
        step(); chk("R2 seq", 16'h0040, 1'b0);
        step(); chk("R4 predicted target", 16'h0200, 1'b1);
        step(); chk("R7 first after prediction", 16'h0204, 1'b0);
        step(); chk("R7 second after prediction", 16'h0208, 1'b0);

        // R7: branch at first or second fetch after redirect is not predicted
        redir(16'h003C); chk("R3 redirect", 16'h003C, 1'b0);
        step(); chk("R7 second fetch is branch", 16'h0040, 1'b0);
        step(); chk("R7 second fetch unpredicted", 16'h0044, 1'b0);
        redir(16'h0040); chk("R7 first fetch is branch", 16'h0040, 1'b0);
        step(); chk("R7 first fetch unpredicted", 16'h0044, 1'b0);

        // R7: third fetch after a predicted redirect can predict
        upd(16'h0208, 16'h0300, 1'b1);
        redir(16'h0038);
        step(); step();
        step(); chk("R4 predicted", 16'h0200, 1'b1);
        step(); chk("R7 seq", 16'h0204, 1'b0);
        step(); chk("R7 seq", 16'h0208, 1'b0);
        step(); chk("R7 third after prediction", 16'h0300, 1'b1);

        // R5: alias at index 0 with different tag replaces the entry
        upd(16'h0080, 16'h0400, 1'b1);
        redir(16'h0038);
        step(); step();
        step(); chk("R5 replaced entry no hit", 16'h0044, 1'b0);
        redir(16'h0078);
        step(); step();
        step(); chk("R5 new tag hits", 16'h0400, 1'b1);

        // R6: not-taken update clears the entry
        upd(16'h0080, 16'h0400, 1'b0);
        redir(16'h0078);
        step(); step(); chk("R6 seq", 16'h0080, 1'b0);
        step(); chk("R6 cleared entry no hit", 16'h0084, 1'b0);

        // R3: external redirect beats a due prediction; low bits ignored
        upd(16'h0040, 16'h0200, 1'b1);
        redir(16'h0038);
        step(); step(); chk("R3 at branch", 16'h0040, 1'b0);
        redir(16'h1000); chk("R3 redirect wins over prediction", 16'h1000, 1'b0);
        redir(16'h1003); chk("R3 low bits cleared", 16'h1000, 1'b0);
        step(); chk("R2 seq after redirect", 16'h1004, 1'b0);

        // R8: update in the cycle the lookup reads is not seen
        redir(16'h0100);
        upd(16'h0108, 16'h0500, 1'b1); chk("R8 seq", 16'h0104, 1'b0);
        step(); chk("R8 seq", 16'h0108, 1'b0);
        step(); chk("R8 same-cycle update unseen", 16'h010C, 1'b0);
        redir(16'h0100);
        step(); step();
        step(); chk("R8 later lookup sees update", 16'h0500, 1'b1);
        // R8: update one cycle before the read is seen
        upd(16'h0108, 16'h0500, 1'b0);
        redir(16'h00FC);
        upd(16'h0108, 16'h0500, 1'b1); chk("R8 seq", 16'h0100, 1'b0);
        step(); step(); chk("R8 seq", 16'h0108, 1'b0);
        step(); chk("R8 earlier update seen", 16'h0500, 1'b1);

        // sweep every index and every redirect distance (R5 R6 R7)
        for (int idx = 0; idx < 16; idx++) begin
            logic [AW-1:0] b;
            logic [AW-1:0] t;
            b = AW'((5 << 6) | (idx << 2));
            t = AW'(16'h2000 + idx * 16);
            upd(b, t, 1'b1);
            for (int j = 0; j < 4; j++) begin
                redir(b - AW'(4 * j));
                chk("R3 sweep redirect", b - AW'(4 * j), 1'b0);
                for (int s = 1; s <= j; s++) begin
                    step();
                    chk("R7 sweep approach", b - AW'(4 * j) + AW'(4 * s), 1'b0);
                end
                step();
                if (j >= 2) chk("R7 sweep third fetch predicts", t, 1'b1);
                else        chk("R7 sweep early fetch unpredicted", b + AW'(4), 1'b0);
            end
            upd(b, t, 1'b0);
            redir(b - AW'(8));
            step(); step();
            step(); chk("R6 sweep cleared", b + AW'(4), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule